// File: doc/BRIEF.md
# Streaming Byte-Wide CRC-16 Accumulator

This block folds a stream of bytes into a 16-bit cyclic redundancy check, one byte per clock. A frame is marked by a start flag on its first byte and an end flag on its last byte. Only cycles with the valid input high carry a byte. When the last byte of a frame arrives, the block latches the conditioned checksum and raises a done pulse for one cycle. Frames may be of any length and may follow each other with no idle cycle between them.

The checksum uses the generator x^16 + x^15 + x^2 + 1 (0x8005). Input bytes are reflected and the remainder starts from all ones. The result is taken bit-reversed and inverted. The internal remainder keeps its raw form, so the next byte is always folded into the unreflected, uninverted value. On a start byte, a selector feeds the all-ones seed into the update in place of the stored remainder. The first byte of a new frame is therefore absorbed in the same cycle that a new frame is recognised.

Top module: `crc16_stream`

## Requirements
- R1: The result equals the CRC with polynomial 0x8005, reflected input bytes, seed 0xFFFF, and output equal to the bit-reversed remainder XOR 0xFFFF; the ASCII string "123456789" gives 0xB4C8.
- R2: The four-byte frame 0x01, 0x02, 0x03, 0x04 gives crc_out = 0xD45E.
- R3: A cycle with in_valid low has no effect: its byte, in_sof and in_eof are ignored, no done pulse follows, and the final CRC is that of the valid bytes only.
- R4: A frame may start on the cycle right after the previous frame's last byte; both frames give their own correct CRC.
- R5: A valid byte with in_eof high makes crc_done high in the next cycle only (exactly one cycle), with crc_out holding that frame's CRC; crc_out keeps that value until the next valid end byte.
- R6: A frame whose single byte carries both in_sof and in_eof gives the CRC of that byte starting from the seed.
- R7: Synchronous active-high reset clears crc_done and crc_out to 0x0000 and loads the remainder with 0xFFFF, so a frame sent after reset without a start flag still starts from the seed.
- R8: Long frames (128 bytes) give the correct CRC.
- R9: A start byte in the middle of a frame discards the bytes before it; the result covers only bytes from the latest start byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Data byte |
| in_valid | input | 1 | Byte is valid this cycle |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| crc_out | output | 16 | Conditioned CRC of the last finished frame |
| crc_done | output | 1 | One-cycle pulse when crc_out is updated |

## Verification
The checksum is tried against two fixed answers, the short count pattern and the nine-digit ASCII string. These catch errors in the polynomial, the reflection or the output conditioning. Frames with interleaved invalid cycles carrying junk bytes and stray flags show whether the enable truly gates the update. Back-to-back, single-byte and restarted frames test the seed selector on every path into the loop. A 128-byte frame shows that the running state keeps its raw form over many iterations. Every result is compared against a model written in the right-shifting form, which shares no structure with the design.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int CRC_W  = 16;
    localparam int DATA_W = 8;

    localparam logic [CRC_W-1:0] CRC_POLY   = 16'h8005;
    localparam logic [CRC_W-1:0] CRC_SEED   = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_XOROUT = 16'hFFFF;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [DATA_W-1:0] byte_t;

    // One accepted input beat as seen by the remainder register.
    typedef struct packed {
        logic  valid;
        logic  restart;
        byte_t data;
    } beat_t;

    function automatic byte_t flip_byte(input byte_t v);
        byte_t r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = v[DATA_W-1-i];
        end
        return r;
    endfunction

    function automatic crc_t flip_crc(input crc_t v);
        crc_t r;
        for (int i = 0; i < CRC_W; i++) begin
            r[i] = v[CRC_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc16_byte_update.sv
module crc16_byte_update
    import crc16_pkg::*;
#(
    parameter int               W      = CRC_W,
    parameter int               DW     = DATA_W,
    parameter logic [W-1:0]     POLY   = CRC_POLY
) (
    input  logic [W-1:0]  state_in,
    input  logic [DW-1:0] data_in,
    output logic [W-1:0]  state_out
);

    // Eight serial shift steps flattened into one XOR network.
    logic [W-1:0] chain [0:DW];

    assign chain[0] = state_in;

    for (genvar k = 0; k < DW; k++) begin : g_step
        logic fb;
        assign fb           = chain[k][W-1] ^ data_in[DW-1-k];
        assign chain[k+1]   = {chain[k][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign state_out = chain[DW];

endmodule

// File: rtl/crc16_remainder.sv
module crc16_remainder
    import crc16_pkg::*;
#(
    parameter crc_t SEED = CRC_SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    output crc_t  rem_q,
    output crc_t  rem_next
);

    crc_t base;

    // Seed selector: a start byte folds straight into the seed.
    assign base = beat.restart ? SEED : rem_q;

    crc16_byte_update #(
        .W    (CRC_W),
        .DW   (DATA_W),
        .POLY (CRC_POLY)
    ) u_update (
        .state_in  (base),
        .data_in   (flip_byte(beat.data)),
        .state_out (rem_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= SEED;
        end else if (beat.valid) begin
            rem_q <= rem_next;
        end
    end

    // R3: no change to the remainder on a cycle without a valid byte
    p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !beat.valid |=> $stable(rem_q));

    // R7: remainder holds the seed right after reset
    p_seed_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rem_q == SEED);

endmodule

// File: rtl/crc16_out_stage.sv
module crc16_out_stage
    import crc16_pkg::*;
#(
    parameter crc_t XOROUT = CRC_XOROUT
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  crc_t rem_next,
    output crc_t crc_out,
    output logic crc_done
);

    crc_t conditioned;

    // Reflection and inversion live only here, outside the loop.
    assign conditioned = flip_crc(rem_next) ^ XOROUT;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_out  <= '0;
            crc_done <= 1'b0;
        end else begin
            crc_done <= fire;
            if (fire) begin
                crc_out <= conditioned;
            end
        end
    end

    // R5: done only follows an accepted end byte
    p_done_after_end_r5: assert property (@(posedge clk) disable iff (rst)
        crc_done |-> $past(fire));

    // R5: output holds unless a frame ends
    p_out_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(crc_out));

endmodule

// File: rtl/crc16_stream.sv
module crc16_stream
    import crc16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  in_byte,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic [15:0] crc_out,
    output logic        crc_done
);

    beat_t beat;
    crc_t  rem_q;
    crc_t  rem_next;
    logic  fire;

    assign beat.valid   = in_valid;
    assign beat.restart = in_sof;
    assign beat.data    = in_byte;
    assign fire         = in_valid & in_eof;

    crc16_remainder #(
        .SEED (CRC_SEED)
    ) u_rem (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .rem_q    (rem_q),
        .rem_next (rem_next)
    );

    crc16_out_stage #(
        .XOROUT (CRC_XOROUT)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .rem_next (rem_next),
        .crc_out  (crc_out),
        .crc_done (crc_done)
    );

    // R5: a done pulse never lasts two cycles unless two frames end back to back
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        crc_done && !$past(fire, 2) |=> !crc_done || $past(fire));

    // R3: invalid cycles never produce a done pulse
    p_idle_no_done_r3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !crc_done);

endmodule

// File: tb/crc16_stream_test.sv
`timescale 1ns/1ps
module crc16_stream_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_byte = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [15:0] crc_out;
    logic        crc_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] frame [0:255];

    always #5 clk = ~clk;

    crc16_stream uut (
        .clk      (clk),
        .rst      (rst),
        .in_byte  (in_byte),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .crc_out  (crc_out),
        .crc_done (crc_done)
    );

    // Right-shifting reference model over frame[0:len-1].
    function automatic logic [15:0] model(input int len);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            c ^= {8'h00, frame[i]};
            for (int b = 0; b < 8; b++) begin
                c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
            end
        end
        return c ^ 16'hFFFF;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        in_valid = 0; in_sof = 0; in_eof = 0; in_byte = 8'h00;
    endtask

    // Drives frame[0:len-1]; optional junk cycles between bytes; optional
    // check of a previous frame's result at the first byte's edge.
    task automatic push_frame(input int len, input bit gaps, input bit use_sof,
                              input bit chk, input logic [15:0] prev_exp, input string tag);
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 2 == 1)) begin
                @(negedge clk);
                in_valid = 0; in_sof = 1; in_eof = 1; in_byte = 8'hA5;
                @(negedge clk);
                check({tag, " R3 no done on idle"}, {15'd0, crc_done}, 16'd0);
            end else begin
                @(negedge clk);
            end
            if (i == 0 && chk) begin
                check({tag, " done"}, {15'd0, crc_done}, 16'd1);
                check({tag, " crc"}, crc_out, prev_exp);
            end
            in_valid = 1; in_sof = use_sof && (i == 0); in_eof = (i == len - 1); in_byte = frame[i];
        end
    endtask

    task automatic finish_check(input string tag, input logic [15:0] exp);
        @(negedge clk);
        check({tag, " done"}, {15'd0, crc_done}, 16'd1);
        check({tag, " crc"}, crc_out, exp);
        go_idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 reset done", {15'd0, crc_done}, 16'd0);
        check("R7 reset crc", crc_out, 16'h0000);
        for (int i = 0; i < 4; i++) frame[i] = 8'(i + 1);
        push_frame(4, 0, 0, 0, 16'h0, "R7");
        finish_check("R7 no-sof after reset", 16'hD45E);
    endtask

    task automatic t_known();
        string s = "123456789";
        for (int i = 0; i < 4; i++) frame[i] = 8'(i + 1);
        push_frame(4, 0, 1, 0, 16'h0, "R2");
        finish_check("R2 count frame", 16'hD45E);
        for (int i = 0; i < 9; i++) frame[i] = s[i];
        push_frame(9, 0, 1, 0, 16'h0, "R1");
        finish_check("R1 ascii check", 16'hB4C8);
        check("R1 model agrees", model(9), 16'hB4C8);
    endtask

    task automatic t_gaps();
        logic [15:0] e;
        for (int i = 0; i < 10; i++) frame[i] = 8'(8'h30 + 3 * i);
        e = model(10);
        push_frame(10, 1, 1, 0, 16'h0, "R3");
        finish_check("R3 gapped frame", e);
    endtask

    task automatic t_back2back();
        logic [15:0] ea, eb;
        for (int i = 0; i < 5; i++) frame[i] = 8'(8'hC0 ^ i);
        ea = model(5);
        push_frame(5, 0, 1, 0, 16'h0, "R4a");
        for (int i = 0; i < 6; i++) frame[i] = 8'(8'h11 * i);
        eb = model(6);
        push_frame(6, 0, 1, 1, ea, "R4 first frame");
        finish_check("R4 second frame", eb);
    endtask

    task automatic t_single();
        logic [15:0] e0, e1;
        frame[0] = 8'h00; e0 = model(1);
        frame[0] = 8'hFF; e1 = model(1);
        frame[0] = 8'h00;
        push_frame(1, 0, 1, 0, 16'h0, "R6");
        frame[0] = 8'hFF;
        push_frame(1, 0, 1, 1, e0, "R6 byte 00");
        finish_check("R6 byte FF", e1);
    endtask

    task automatic t_hold();
        logic [15:0] e;
        for (int i = 0; i < 3; i++) frame[i] = 8'(8'h5A + i);
        e = model(3);
        push_frame(3, 0, 1, 0, 16'h0, "R5");
        finish_check("R5 end", e);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 done low after pulse", {15'd0, crc_done}, 16'd0);
            check("R5 crc held idle", crc_out, e);
        end
        // Partial frame, no end byte: output must not move.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_eof = 0; in_byte = 8'(8'h90 + i);
        end
        @(negedge clk);
        go_idle();
        check("R5 crc held mid-frame", crc_out, e);
        check("R5 no done mid-frame", {15'd0, crc_done}, 16'd0);
    endtask

    task automatic t_restart();
        logic [15:0] e;
        for (int i = 0; i < 3; i++) frame[i] = 8'(8'hE0 + i);
        push_frame(3, 0, 1, 0, 16'h0, "R9");
        @(negedge clk);
        in_eof = 0;
        in_valid = 0;
        for (int i = 0; i < 4; i++) frame[i] = 8'(8'h21 + 2 * i);
        e = model(4);
        push_frame(4, 0, 1, 0, 16'h0, "R9");
        finish_check("R9 restart discards", e);
    endtask

    task automatic t_restart_mid();
        logic [15:0] e;
        // First byte of old frame without end, then a fresh start.
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_eof = 0; in_byte = 8'(8'h77 + i);
        end
        for (int i = 0; i < 4; i++) frame[i] = 8'(8'h21 + 2 * i);
        e = model(4);
        push_frame(4, 0, 1, 0, 16'h0, "R9");
        finish_check("R9 mid-frame start", e);
    endtask

    task automatic t_long();
        logic [15:0] e;
        for (int i = 0; i < 128; i++) frame[i] = 8'(i * 7 + 3);
        e = model(128);
        push_frame(128, 0, 1, 0, 16'h0, "R8");
        finish_check("R8 128-byte frame", e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_known();
        t_gaps();
        t_back2back();
        t_single();
        t_hold();
        t_restart();
        t_restart_mid();
        t_long();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule